// File: doc/BRIEF.md
# Port Write Cycle Generator

This block acts as a simple bus master for exercising an 8-bit peripheral port interface. It takes 10-bit request words through a valid/ready handshake. Each word holds a 2-bit port select and a data byte. For each word it plays out one write cycle on a set of address, data and active-low strobe lines.

The timing is counted in bus clocks. A bus clock is not a separate input. It is derived from the fast system clock by a divider whose ratio (system clocks per bus clock) is a programmable input. Every cycle lasts five bus clocks: one clock of setup with address and data already driven, three clocks with the strobe low, and one clock of recovery with the strobe high again. A one-cycle completion pulse follows, and the generator then waits in idle for the next word. For example, a ratio of 12 or 13 from a 125 MHz system clock approximates a 10 MHz bus, which gives a cycle of about 500 ns.

Top module: `iowr_cycle_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_wr_n` is 1, `req_ready` is 1, `done` is 0, and `bus_addr` and `bus_data` are 0.
- R2: An accepted request word drives `bus_addr` from bits [9:8] and `bus_data` from bits [7:0].
- R3: `req_ready` is 1 only while idle. A word is taken at a rising clock edge where `req_valid` and `req_ready` are both 1. Words presented while busy are ignored until idle returns.
- R4: Let N be the effective ratio. For the first N system clocks after acceptance, `bus_wr_n` stays 1 while address and data are already driven.
- R5: `bus_wr_n` is then 0 for exactly 3·N system clocks.
- R6: A recovery phase of N system clocks with `bus_wr_n` at 1 follows. Address and data stay unchanged from acceptance to the end of recovery.
- R7: `done` is 1 for exactly one system clock, in the clock cycle immediately after recovery. `req_ready` is 1 in that same cycle, so the active cycle totals 5·N clocks.
- R8: N is `div_ticks` sampled at acceptance, with 0 treated as 1. Changes to `div_ticks` during a cycle do not affect that cycle.
- R9: While idle with no request, `bus_wr_n` stays 1, `done` stays 0, and `bus_addr`/`bus_data` keep their last values.
- R10: A request held valid through a cycle is accepted in the `done` cycle, and its setup starts in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ticks | input | 8 | System clocks per bus clock (0 acts as 1) |
| req_valid | input | 1 | Request word available |
| req_word | input | 10 | Port select [9:8], data byte [7:0] |
| req_ready | output | 1 | Generator idle and able to take a word |
| bus_addr | output | 2 | Port select lines |
| bus_data | output | 8 | Data lines |
| bus_wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse after each completed cycle |

## Verification
Count from the clock edge that accepts a word. The outputs at clock k after it are fixed by N alone:
- Address and data are valid from k=1.
- The strobe is low for N < k ≤ 4N.
- `done` and `req_ready` rise together at k = 5N+1.

The bench samples each clock on the falling edge after acceptance. It compares every output against this schedule, computed from the effective ratio it latched itself. It alters `div_ticks` and holds `req_valid` high with another word mid-cycle, so that R3 and R8 are checked against the same schedule.

// File: rtl/iowr_pkg.sv
package iowr_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int WORD_W = ADDR_W + DATA_W;

    // bus clocks spent in each phase of one write cycle
    localparam int SETUP_CLKS  = 1;
    localparam int STROBE_CLKS = 3;
    localparam int RECOV_CLKS  = 1;
    localparam int PH_CNT_W    = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic wr_req_t unpack_word(input logic [WORD_W-1:0] w);
        wr_req_t r;
        r.addr = w[WORD_W-1:DATA_W];
        r.data = w[DATA_W-1:0];
        return r;
    endfunction

    function automatic logic [PH_CNT_W-1:0] phase_last(input phase_e ph);
        case (ph)
            PH_SETUP:  return PH_CNT_W'(SETUP_CLKS - 1);
            PH_STROBE: return PH_CNT_W'(STROBE_CLKS - 1);
            PH_RECOV:  return PH_CNT_W'(RECOV_CLKS - 1);
            default:   return '0;
        endcase
    endfunction

    function automatic phase_e phase_next(input phase_e ph);
        case (ph)
            PH_SETUP:  return PH_STROBE;
            PH_STROBE: return PH_RECOV;
            default:   return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/iowr_tick_div.sv
module iowr_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,   // already normalised to >= 1
    output logic             tick
);
    logic [DIV_W-1:0] count;

    assign tick = run && (count == limit - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            count <= '0;
        end else begin
            count <= count + DIV_W'(1);
        end
    end
endmodule

// File: rtl/iowr_phase_seq.sv
module iowr_phase_seq
    import iowr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   tick,
    output phase_e phase,
    output logic   done
);
    logic [PH_CNT_W-1:0] bclk;
    logic                last;

    assign last = tick && (bclk == phase_last(phase));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            bclk  <= '0;
            done  <= 1'b0;
        end else begin
            done <= (phase == PH_RECOV) && last;
            if (phase == PH_IDLE) begin
                bclk <= '0;
                if (start) begin
                    phase <= PH_SETUP;
                end
            end else if (last) begin
                bclk  <= '0;
                phase <= phase_next(phase);
            end else if (tick) begin
                bclk <= bclk + PH_CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/iowr_req_hold.sv
module iowr_req_hold
    import iowr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    input  logic [DIV_W-1:0]  div_in,
    output wr_req_t           req,
    output logic [DIV_W-1:0]  div_eff
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= '0;
            div_eff <= DIV_W'(1);
        end else if (take) begin
            req     <= unpack_word(word);
            div_eff <= (div_in == '0) ? DIV_W'(1) : div_in;
        end
    end
endmodule

// File: rtl/iowr_cycle_gen.sv
module iowr_cycle_gen
    import iowr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_ticks,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_wr_n,
    output logic              done
);
    phase_e           phase;
    wr_req_t          held;
    logic [DIV_W-1:0] div_eff;
    logic             take;
    logic             tick;

    assign req_ready = (phase == PH_IDLE);
    assign take      = req_valid && req_ready;

    iowr_req_hold #(.DIV_W(DIV_W)) u_hold (
        .clk(clk), .rst(rst), .take(take), .word(req_word),
        .div_in(div_ticks), .req(held), .div_eff(div_eff)
    );

    iowr_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(phase != PH_IDLE),
        .limit(div_eff), .tick(tick)
    );

    iowr_phase_seq u_seq (
        .clk(clk), .rst(rst), .start(take), .tick(tick),
        .phase(phase), .done(done)
    );

    assign bus_addr = held.addr;
    assign bus_data = held.data;
    assign bus_wr_n = (phase != PH_STROBE);
endmodule

// File: rtl/iowr_cycle_gen_chk.sv
module iowr_cycle_gen_chk
    import iowr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_wr_n,
    input logic              done
);
    a_r3_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r5_strobe_only_busy: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> !req_ready);

    a_r4_fall_after_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr_n) |-> $past(!req_ready));

    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> ($stable(bus_addr) && $stable(bus_data)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && bus_wr_n && $past(!req_ready)));
endmodule

bind iowr_cycle_gen iowr_cycle_gen_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_wr_n(bus_wr_n), .done(done)
);

// File: tb/test_iowr_cycle_gen.sv
module test_iowr_cycle_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_ticks = 8'd4;
    logic       req_valid = 1'b0;
    logic [9:0] req_word  = '0;
    logic       req_ready;
    logic [1:0] bus_addr;
    logic [7:0] bus_data;
    logic       bus_wr_n;
    logic       done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    iowr_cycle_gen i_iowr_cycle_gen (
        .clk(clk), .rst(rst), .div_ticks(div_ticks), .req_valid(req_valid),
        .req_word(req_word), .req_ready(req_ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_wr_n(bus_wr_n), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_n(input int dv);
        return (dv == 0) ? 1 : dv;
    endfunction

    function automatic bit exp_wr_n(input int k, input int n);
        return !(k > n && k <= 4 * n);
    endfunction

    // Called at a falling edge with the generator idle; returns at the
    // falling edge of the done cycle.
    task automatic run_cycle(input logic [9:0] w, input int dv,
                             input bit keep_valid, input logic [9:0] nxt);
        int n;
        n = eff_n(dv);
        check(req_ready == 1'b1, "R3 ready before request", int'(req_ready), 1);
        div_ticks = 8'(dv);
        req_word  = w;
        req_valid = 1'b1;
        for (int k = 1; k <= 5 * n + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = keep_valid;   // R3: ignored while busy
                req_word  = nxt;
                div_ticks = 8'($urandom_range(0, 255)); // R8: no effect now
            end
            check(bus_wr_n == exp_wr_n(k, n), "R4 R5 R6 strobe", int'(bus_wr_n), int'(exp_wr_n(k, n)));
            check(bus_addr == w[9:8], "R2 R6 address", int'(bus_addr), int'(w[9:8]));
            check(bus_data == w[7:0], "R2 R6 data", int'(bus_data), int'(w[7:0]));
            check(done == (k == 5 * n + 1), "R7 done", int'(done), int'(k == 5 * n + 1));
            check(req_ready == (k == 5 * n + 1), "R3 R7 ready", int'(req_ready), int'(k == 5 * n + 1));
        end
    endtask

    task automatic idle_check(input int cycles);
        logic [1:0] a0;
        logic [7:0] d0;
        a0 = bus_addr;
        d0 = bus_data;
        req_valid = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(bus_wr_n && req_ready && !done, "R9 idle outputs", int'({bus_wr_n, req_ready, done}), 3'b110);
            check(bus_addr == a0 && bus_data == d0, "R9 idle hold", int'({bus_addr, bus_data}), int'({a0, d0}));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(bus_wr_n == 1'b1, "R1 reset strobe", int'(bus_wr_n), 1);
        check(req_ready == 1'b1 && done == 1'b0, "R1 reset ready/done", int'({req_ready, done}), 2);
        check(bus_addr == 0 && bus_data == 0, "R1 reset lines", int'({bus_addr, bus_data}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(bus_wr_n == 1'b1 && req_ready == 1'b1 && done == 1'b0, "R1 after reset", int'({bus_wr_n, req_ready, done}), 3'b110);

        idle_check(5);                       // R9 with no request
        run_cycle(10'h3A5, 1, 1'b0, 10'h000); // R4 smallest ratio
        idle_check(4);
        run_cycle(10'h15A, 0, 1'b0, 10'h2FF); // R8 zero acts as one
        idle_check(3);                       // R9 hold after a cycle
        run_cycle(10'h2C3, 3, 1'b1, 10'h1E7); // R10 chained
        run_cycle(10'h1E7, 5, 1'b1, 10'h0FF); // R10 chained again
        run_cycle(10'h0FF, 2, 1'b0, 10'h3FF);
        idle_check(2);
        run_cycle(10'h300, 40, 1'b0, 10'h001); // large ratio

        for (int i = 0; i < 40; i++) begin
            logic [9:0] w;
            logic [9:0] nw;
            int dv;
            bit chain;
            w     = 10'($urandom_range(0, 1023));
            nw    = 10'($urandom_range(0, 1023));
            dv    = $urandom_range(0, 14);
            chain = 1'($urandom_range(0, 1));
            run_cycle(w, dv, 1'b0, nw);
            if (!chain) idle_check(int'($urandom_range(1, 6)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule